// File: doc/BRIEF.md
# Sleep Timer with Derived Watchdog

This block runs a periodic sleep timer from a slow low-power tick enable and derives a watchdog from it. The sleep timer counts ticks up to a period picked by a 2-bit select. Each time it wraps, it raises a one-cycle sleep interrupt. The watchdog counts these wraps. On the third counted wrap it emits a one-cycle watchdog reset pulse.

The block holds one status register whose only live bit is a power-on flag. A power-on reset sets this flag, and software can only clear it. Clearing the flag arms the watchdog. From then on, only another power-on reset disarms it. Software keeps the watchdog quiet by writing to a clear register. Any write to that register zeroes the wrap count. A write of one special value also restarts the sleep timer. Because the sleep timer is shared, the true watchdog timeout lies between two and three sleep periods.

Top module: `slpwd_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `status` reads 0x10, `wdt_armed` is 0, and `sleep_irq` and `wdt_rst` are 0.
- R2: A status write (`wr_en`=1, `wr_sel`=0) with `wr_data[4]`=0 clears `status[4]` one cycle later. A status write with `wr_data[4]`=1 leaves the flag unchanged, so the flag is never set by a write. All other `status` bits always read 0.
- R3: `wdt_armed` is the inverse of `status[4]`. While the block is not armed, `wdt_rst` stays 0 no matter how many sleep wraps occur.
- R4: Once armed, the block stays armed through any status writes and through watchdog resets. Only `rst` disarms it.
- R5: For `period_sel` values 0, 1, 2 and 3, the sleep period is 2^(BASE_LOG2 + STEP_LOG2*period_sel) ticks. The timer advances only in cycles where `tick_en`=1.
- R6: In a cycle where `tick_en`=1 and the timer sits at its last count, the timer wraps to 0. `sleep_irq` is then high for exactly the next cycle.
- R7: While armed, `wdt_rst` is high for one cycle on the third counted wrap, in the same cycle as that wrap's `sleep_irq`.
- R8: Any write to the clear register (`wr_en`=1, `wr_sel`=1) zeroes the wrap count. A wrap in that same cycle is not counted, but it still raises `sleep_irq` unless the data is 0x38.
- R9: A clear-register write of exactly 0x38 also zeroes the sleep timer count. A tick in that same cycle is dropped and produces no wrap.
- R10: A watchdog reset zeroes the wrap count and leaves `status[4]` at 0, so the next watchdog reset comes three wraps later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| tick_en | input | 1 | Slow-clock tick enable |
| period_sel | input | 2 | Sleep period select |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status, 1 watchdog clear |
| wr_data | input | 8 | Write data |
| sleep_irq | output | 1 | One-cycle sleep interrupt request |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |
| wdt_armed | output | 1 | Watchdog enabled |
| status | output | 8 | Status register contents |

## Verification
The bench builds the block with BASE_LOG2=2 and STEP_LOG2=1. This gives sleep periods of 4, 8, 16 and 32 ticks, so every period select and dozens of watchdog timeouts fit in a short run. These short periods also let clear-register writes land in every phase of the timer, including the exact wrap cycle, where the 0x38 write and the plain clear behave differently. Irregular tick patterns show that only enabled cycles advance the count.

// File: rtl/slpwd_pkg.sv
package slpwd_pkg;

    localparam int unsigned WD_LIMIT   = 3;
    localparam int unsigned WD_CNT_W   = 2;
    localparam int unsigned FLAG_BIT   = 4;
    localparam logic [7:0]  FULL_CLEAR = 8'h38;

    typedef enum logic {
        REG_STATUS = 1'b0,
        REG_WDCLR  = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic clr_count;
        logic clr_timer;
        logic wr_status;
        logic keep_flag;
    } wr_decode_t;

    function automatic int unsigned period_last(input logic [1:0] sel,
                                                input int unsigned base_log2,
                                                input int unsigned step_log2);
        return (32'd1 << (base_log2 + step_log2 * sel)) - 32'd1;
    endfunction

    function automatic wr_decode_t decode_write(input logic en,
                                                input logic sel,
                                                input logic [7:0] data);
        wr_decode_t d;
        d.clr_count = en && (reg_sel_e'(sel) == REG_WDCLR);
        d.clr_timer = d.clr_count && (data == FULL_CLEAR);
        d.wr_status = en && (reg_sel_e'(sel) == REG_STATUS);
        d.keep_flag = data[FLAG_BIT];
        return d;
    endfunction

endpackage

// File: rtl/slpwd_sleep_tmr.sv
module slpwd_sleep_tmr
    import slpwd_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 6,
    parameter int unsigned STEP_LOG2 = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic [1:0] period_sel,
    input  logic       clr,
    output logic       wrap,
    output logic       irq
);
    localparam int unsigned CNT_W = BASE_LOG2 + 3 * STEP_LOG2;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    always_comb last = CNT_W'(period_last(period_sel, BASE_LOG2, STEP_LOG2));

    assign wrap = tick_en && !clr && (cnt >= last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            irq <= wrap;
            if (clr)
                cnt <= '0;
            else if (tick_en)
                cnt <= (cnt >= last) ? '0 : cnt + 1'b1;
        end
    end

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R6
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !clr) |=> $stable(cnt)); // R5

endmodule

// File: rtl/slpwd_wdog.sv
module slpwd_wdog
    import slpwd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic wrap,
    input  logic clr,
    output logic wdt_rst
);
    logic [WD_CNT_W-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt    <= '0;
            wdt_rst <= 1'b0;
        end else begin
            wdt_rst <= 1'b0;
            if (clr) begin
                wcnt <= '0;
            end else if (armed && wrap) begin
                if (wcnt == WD_CNT_W'(WD_LIMIT - 1)) begin
                    wcnt    <= '0;
                    wdt_rst <= 1'b1;
                end else begin
                    wcnt <= wcnt + 1'b1;
                end
            end
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        wcnt != WD_CNT_W'(WD_LIMIT)); // R7
    AST_CLR_COUNT: assert property (@(posedge clk) disable iff (rst)
        clr |=> (wcnt == '0) && !wdt_rst); // R8
    AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |=> !wdt_rst); // R10

endmodule

// File: rtl/slpwd_status.sv
module slpwd_status
    import slpwd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_status,
    input  logic keep_flag,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b1;
        else if (wr_status && !keep_flag)
            flag <= 1'b0;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !flag |=> !flag); // R4

endmodule

// File: rtl/slpwd_top.sv
module slpwd_top
    import slpwd_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 6,
    parameter int unsigned STEP_LOG2 = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic [1:0] period_sel,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    output logic       sleep_irq,
    output logic       wdt_rst,
    output logic       wdt_armed,
    output logic [7:0] status
);
    wr_decode_t dec;
    logic       wrap;
    logic       flag;

    always_comb dec = decode_write(wr_en, wr_sel, wr_data);

    slpwd_sleep_tmr #(
        .BASE_LOG2 (BASE_LOG2),
        .STEP_LOG2 (STEP_LOG2)
    ) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .period_sel (period_sel),
        .clr        (dec.clr_timer),
        .wrap       (wrap),
        .irq        (sleep_irq)
    );

    slpwd_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .wr_status (dec.wr_status),
        .keep_flag (dec.keep_flag),
        .flag      (flag)
    );

    slpwd_wdog u_wd (
        .clk     (clk),
        .rst     (rst),
        .armed   (!flag),
        .wrap    (wrap),
        .clr     (dec.clr_count),
        .wdt_rst (wdt_rst)
    );

    assign wdt_armed = !flag;

    always_comb begin
        status           = '0;
        status[FLAG_BIT] = flag;
    end

    AST_RST_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |-> wdt_armed); // R3
    AST_RST_WITH_IRQ: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |-> sleep_irq); // R7

endmodule

// File: tb/slpwd_top_tb_top.sv
module slpwd_top_tb_top;
    localparam int unsigned B = 2;
    localparam int unsigned S = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [1:0] period_sel = 2'd0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       sleep_irq, wdt_rst, wdt_armed;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;
    int m_sc = 0, m_wc = 0;
    bit m_flag = 1, m_irq = 0, m_wrst = 0;
    int n_irq = 0, n_wrst = 0;
    string ctx = "R1 reset";

    always #5 clk = ~clk;

    slpwd_top #(.BASE_LOG2(B), .STEP_LOG2(S)) dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .period_sel(period_sel),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sleep_irq(sleep_irq), .wdt_rst(wdt_rst), .wdt_armed(wdt_armed),
        .status(status)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", ctx, what, act, exp);
        end
    endtask

    task automatic model_step();
        int  last;
        bit  clr38, clrw, ovf;
        if (rst) begin
            m_sc = 0; m_wc = 0; m_flag = 1; m_irq = 0; m_wrst = 0;
            return;
        end
        last  = (1 << (B + S * period_sel)) - 1;
        clrw  = wr_en && wr_sel;
        clr38 = clrw && (wr_data == 8'h38);
        ovf   = tick_en && !clr38 && (m_sc >= last);
        m_irq  = ovf;
        m_wrst = 0;
        if (clrw) m_wc = 0;
        else if (!m_flag && ovf) begin
            if (m_wc == 2) begin m_wc = 0; m_wrst = 1; end
            else m_wc++;
        end
        if (wr_en && !wr_sel && !wr_data[4]) m_flag = 0;
        if (clr38) m_sc = 0;
        else if (tick_en) m_sc = (m_sc >= last) ? 0 : m_sc + 1;
    endtask

    task automatic step(input bit t, input bit we = 0, input bit ws = 0,
                        input logic [7:0] wd = 8'h00);
        tick_en = t; wr_en = we; wr_sel = ws; wr_data = wd;
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R2 status", int'(status), m_flag ? 16 : 0);
        chk("R3 armed", int'(wdt_armed), int'(!m_flag));
        chk("R6 sleep_irq", int'(sleep_irq), int'(m_irq));
        chk("R7 wdt_rst", int'(wdt_rst), int'(m_wrst));
        if (sleep_irq) n_irq++;
        if (wdt_rst) n_wrst++;
        tick_en = 0; wr_en = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired: actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst = 1;
        for (int i = 0; i < 3; i++) step(1);
        rst = 0;
        ctx = "R1 after reset";
        step(0);
        chk("R1 status", int'(status), 16);
        chk("R1 wdt_rst", int'(wdt_rst), 0);

        ctx = "R2 set attempt";
        step(0, 1, 0, 8'hFF);
        chk("R2 flag kept", int'(status), 16);

        ctx = "R3 unarmed wraps";
        n_wrst = 0;
        for (int i = 0; i < 60; i++) step(1);
        chk("R3 no wdt_rst", n_wrst, 0);

        ctx = "R5 period sweep";
        for (int p = 0; p < 4; p++) begin
            period_sel = 2'(p);
            step(0, 1, 1, 8'h38);
            n_irq = 0;
            for (int i = 0; i < 4 * (1 << (B + S * p)); i++) step(1);
            chk("R5 wraps per four periods", n_irq, 4);
        end

        ctx = "R5 sparse ticks";
        period_sel = 2'd1;
        for (int i = 0; i < 200; i++) step(($urandom % 3) == 0);

        ctx = "R2 clear flag";
        step(0, 1, 0, 8'hEF);
        chk("R2 cleared", int'(status), 0);
        chk("R3 armed", int'(wdt_armed), 1);

        ctx = "R10 repeated timeouts";
        period_sel = 2'd0;
        step(0, 1, 1, 8'h38);
        n_wrst = 0;
        for (int i = 0; i < 12 * 4; i++) step(1);
        chk("R10 four timeouts", n_wrst, 4);

        ctx = "R4 status writes after arming";
        step(0, 1, 0, 8'h10);
        step(0, 1, 0, 8'hFF);
        chk("R4 still armed", int'(wdt_armed), 1);

        ctx = "R8 plain clears";
        n_wrst = 0;
        for (int i = 0; i < 300; i++)
            if (i % 9 == 8) step(1, 1, 1, 8'(i)); else step(1);
        chk("R8 no timeouts", n_wrst, 0);

        ctx = "R9 full clears";
        for (int i = 0; i < 300; i++)
            if (i % 7 == 3) step(1, 1, 1, 8'h38); else step(($urandom % 2) == 0);

        ctx = "R8 R9 mixed random";
        for (int i = 0; i < 3000; i++) begin
            period_sel = 2'($urandom % 4);
            case ($urandom % 20)
                0: step($urandom % 2, 1, 1, 8'h38);
                1: step($urandom % 2, 1, 1, 8'($urandom));
                2: step($urandom % 2, 1, 0, 8'($urandom) | 8'h10);
                default: step(($urandom % 4) != 0);
            endcase
        end

        ctx = "R4 reset disarms";
        rst = 1; step(1); rst = 0;
        step(0);
        chk("R4 disarmed", int'(wdt_armed), 0);
        chk("R1 status again", int'(status), 16);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule